// File: doc/BRIEF.md
# Radix Page Table Walker

This block translates an effective address into a real address by walking a radix tree of page directories held in memory. A walk starts from a process ID, the base of a process table and that table's size code. The walker first reads the entry that belongs to the process. That entry gives the root directory base, the index width of the root directory and the number of address bits that the tree translates. The walker then descends one directory at a time. At each level it takes the next group of effective-address bits as an index and reads one 8-byte entry.

Each directory entry is either a pointer to a further directory or a leaf. A leaf can sit at any depth, so a shallow leaf maps a large page. The walker returns the real address, the leaf entry itself, the address the leaf was read from and the page size as a bit count. Invalid entries, an oversized process ID and malformed directory shapes end the walk with a fault cause. Memory is reached through a simple read port: a request with a valid/ready handshake, and a one-beat response with a valid flag.

Top module: `radix_walker`

## Requirements
- R1: When pid*16 is at or above 2^(size code + 12), the walk ends at once with cause 1 (no entry), and no memory read is issued.
- R2: Otherwise the process entry is read at (table base with its low 4 bits cleared) + pid*16. In it, bits 55:8 give the root base (low 8 bits zero), bits 4:0 give the root index width, and bits 61:56 give the total translated size, which is the starting remaining size.
- R3: Before each directory read, an index width below 5 ends the walk with cause 2 (bad configuration), and that level is not read.
- R4: Before each directory read, an index width larger than the remaining size ends the walk with cause 2, and that level is not read.
- R5: A directory entry is read at base + ((EA >> (remaining - width)) & (2^width - 1)) * 8. After the read, the remaining size becomes remaining - width.
- R6: An entry whose bit 63 (valid) is clear ends the walk with cause 1, whatever its other bits hold.
- R7: An entry with bit 63 and bit 62 (leaf) set ends the walk with cause 0. The real address is entry bits 55:0 with their low remaining-size bits replaced by the same EA bits. The block also returns the entry, its address and the remaining size as the page-size exponent. A leaf may appear at any level.
- R8: A valid non-leaf entry supplies the next base (bits 55:8, low 8 bits zero) and the next index width (bits 4:0).
- R9: At most 5 directory levels are read. A valid non-leaf entry at the fifth level ends the walk with cause 2.
- R10: A memory request holds its valid and address until it is accepted. walk_done is a one-cycle pulse, and the results stay stable until the next walk ends. A start is taken only while walk_ready is high; a start while busy is ignored.
- R11: After reset the block is idle: walk_ready is high, and walk_done and mem_rd_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| walk_valid | input | 1 | Start a walk |
| walk_ready | output | 1 | Idle and able to start |
| walk_pid | input | PID_W | Process ID |
| walk_ptab | input | PA_W | Process table base |
| walk_ptsz | input | 5 | Process table size code |
| walk_ea | input | 64 | Effective address |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory accepts the request |
| mem_rd_addr | output | PA_W | Read address (8-byte aligned) |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data |
| walk_done | output | 1 | Walk finished (one-cycle pulse) |
| walk_cause | output | 2 | 0 ok, 1 no entry, 2 bad configuration |
| walk_real | output | PA_W | Translated real address |
| walk_pte | output | 64 | Leaf entry |
| walk_pte_addr | output | PA_W | Address of the leaf entry |
| walk_psize | output | 6 | Page size exponent |

## Verification
The hardest case to reach is the depth limit. A fifth-level non-leaf entry only occurs after five consistent directory reads, each placed at the index that the shrinking remaining size selects from the address. The bench builds such a chain with narrow 5-bit directories under a 40-bit total, so five levels fit before the size runs out. It then ends the chain with a pointer in one run and with a leaf in another. Intruding starts are made possible by stretching walks with a throttled memory ready, which opens a wide busy window.

// File: rtl/radix_walker.sv
module radix_walker #(
  parameter int PA_W       = 56,
  parameter int PID_W      = 20,
  parameter int MAX_LEVELS = 5,
  parameter int MIN_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             walk_valid,
  output logic             walk_ready,
  input  logic [PID_W-1:0] walk_pid,
  input  logic [PA_W-1:0]  walk_ptab,
  input  logic [4:0]       walk_ptsz,
  input  logic [63:0]      walk_ea,
  output logic             mem_rd_valid,
  input  logic             mem_rd_ready,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic             mem_rsp_valid,
  input  logic [63:0]      mem_rsp_data,
  output logic             walk_done,
  output logic [1:0]       walk_cause,
  output logic [PA_W-1:0]  walk_real,
  output logic [63:0]      walk_pte,
  output logic [PA_W-1:0]  walk_pte_addr,
  output logic [5:0]       walk_psize
);
  localparam int LVL_W = $clog2(MAX_LEVELS + 1);
  localparam logic [1:0] C_OK = 2'd0, C_NOENT = 2'd1, C_BAD = 2'd2;

  typedef enum logic [1:0] {IDLE, CHK, REQ, WAIT} st_t;
  st_t state;

  logic             pt_q;
  logic [63:0]      ea_q;
  logic [PA_W-1:0]  base_q, addr_q;
  logic [4:0]       w_q;
  logic [5:0]       rem_q;
  logic [LVL_W-1:0] lvl_q;
  logic             done_q;
  logic [1:0]       cause_q;
  logic [PA_W-1:0]  real_q, paddr_q;
  logic [63:0]      pte_q;
  logic [5:0]       psize_q;

  wire pt_oob = (64'(walk_pid) << 4) >= (64'd1 << (6'(walk_ptsz) + 6'd12));
  wire [PA_W-1:0] pt_addr = (walk_ptab & ~PA_W'(15)) + (PA_W'(walk_pid) << 4);
  wire [5:0] shamt = rem_q - 6'(w_q);
  wire [PA_W-4:0] idx = (PA_W-3)'((ea_q >> shamt) & ((64'd1 << w_q) - 64'd1));
  wire [PA_W-1:0] ent_addr = base_q + {idx, 3'b000};
  wire [PA_W-1:0] low_mask = (PA_W'(1) << shamt) - PA_W'(1);
  wire bad_cfg = (w_q < 5'(MIN_W)) || (6'(w_q) > rem_q);
  wire last_lvl = (lvl_q == LVL_W'(MAX_LEVELS - 1));
  wire [63:0] d = mem_rsp_data;

  assign walk_ready    = (state == IDLE);
  assign mem_rd_valid  = (state == REQ);
  assign mem_rd_addr   = addr_q;
  assign walk_done     = done_q;
  assign walk_cause    = cause_q;
  assign walk_real     = real_q;
  assign walk_pte      = pte_q;
  assign walk_pte_addr = paddr_q;
  assign walk_psize    = psize_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= IDLE;
      pt_q    <= 1'b0;
      ea_q    <= '0;
      base_q  <= '0;
      addr_q  <= '0;
      w_q     <= '0;
      rem_q   <= '0;
      lvl_q   <= '0;
      done_q  <= 1'b0;
      cause_q <= C_OK;
      real_q  <= '0;
      paddr_q <= '0;
      pte_q   <= '0;
      psize_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        IDLE: if (walk_valid) begin
          ea_q <= walk_ea;
          if (pt_oob) begin
            done_q  <= 1'b1;
            cause_q <= C_NOENT;
          end else begin
            addr_q <= pt_addr;
            pt_q   <= 1'b1;
            state  <= REQ;
          end
        end
        CHK: if (bad_cfg) begin
          done_q  <= 1'b1;
          cause_q <= C_BAD;
          state   <= IDLE;
        end else begin
          addr_q <= ent_addr;
          state  <= REQ;
        end
        REQ: if (mem_rd_ready) state <= WAIT;
        WAIT: if (mem_rsp_valid) begin
          if (pt_q) begin
            pt_q   <= 1'b0;
            base_q <= {d[PA_W-1:8], 8'b0};
            w_q    <= d[4:0];
            rem_q  <= d[61:56];
            lvl_q  <= '0;
            state  <= CHK;
          end else if (!d[63]) begin
            done_q  <= 1'b1;
            cause_q <= C_NOENT;
            state   <= IDLE;
          end else if (d[62]) begin
            done_q  <= 1'b1;
            cause_q <= C_OK;
            real_q  <= (d[PA_W-1:0] & ~low_mask) | (ea_q[PA_W-1:0] & low_mask);
            pte_q   <= d;
            paddr_q <= addr_q;
            psize_q <= shamt;
            state   <= IDLE;
          end else if (last_lvl) begin
            done_q  <= 1'b1;
            cause_q <= C_BAD;
            state   <= IDLE;
          end else begin
            base_q <= {d[PA_W-1:8], 8'b0};
            w_q    <= d[4:0];
            rem_q  <= shamt;
            lvl_q  <= lvl_q + 1'b1;
            state  <= CHK;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  // R5
  rd_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> mem_rd_addr[2:0] == 3'b000);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_ready |-> !mem_rd_valid);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> !walk_done);

  // R7
  leaf_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done && walk_cause == C_OK |->
      ((walk_real ^ ea_q[PA_W-1:0]) & ((PA_W'(1) << walk_psize) - PA_W'(1))) == '0);

  // R3
  cause_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |-> walk_cause != 2'd3);

  // R9
  depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state != IDLE |-> lvl_q < LVL_W'(MAX_LEVELS));
endmodule

// File: tb/tb_radix_walker.sv
module tb_radix_walker;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        walk_valid = 1'b0, walk_ready;
  logic [19:0] walk_pid = '0;
  logic [55:0] walk_ptab = '0;
  logic [4:0]  walk_ptsz = '0;
  logic [63:0] walk_ea = '0;
  logic        mem_rd_valid, mem_rd_ready = 1'b0;
  logic [55:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        walk_done;
  logic [1:0]  walk_cause;
  logic [55:0] walk_real, walk_pte_addr;
  logic [63:0] walk_pte;
  logic [5:0]  walk_psize;

  radix_walker dut (.*);

  logic [63:0] mem [logic [55:0]];
  int reads = 0, ncheck = 0, nfail = 0, tick = 0, cyc = 0;
  bit stall = 0, pend = 0;
  logic [55:0] paddr;
  localparam logic [55:0] PTB = 56'h10000;

  function automatic logic [63:0] rd(input logic [55:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  function automatic logic [63:0] pt_ent(input logic [55:0] b, input logic [4:0] w, input logic [5:0] tot);
    return {2'b00, tot, b[55:8], 3'b000, w};
  endfunction
  function automatic logic [63:0] dir_ent(input logic [55:0] b, input logic [4:0] w);
    return {2'b10, 6'b0, b[55:8], 3'b000, w};
  endfunction
  function automatic logic [63:0] leaf_ent(input logic [55:0] rpn);
    return {2'b11, 6'b0, rpn};
  endfunction
  function automatic logic [55:0] eaddr_of(input logic [55:0] b, input int w, input int rem, input logic [63:0] ea);
    logic [63:0] ix;
    ix = (ea >> (rem - w)) & ((64'd1 << w) - 64'd1);
    return b + 56'(ix << 3);
  endfunction

  always @(negedge clk) begin
    tick++;
    if (pend) begin mem_rsp_valid = 1'b1; mem_rsp_data = rd(paddr); pend = 0; end
    else mem_rsp_valid = 1'b0;
    mem_rd_ready = stall ? (tick % 3 == 0) : 1'b1;
    if (rst_n && mem_rd_valid && mem_rd_ready) begin pend = 1; paddr = mem_rd_addr; reads++; end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", ncheck + 1, nfail);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    ncheck++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model(input logic [19:0] pid, input logic [55:0] ptb, input logic [4:0] sz, input logic [63:0] ea,
                       output logic [1:0] c, output logic [55:0] ra, output logic [63:0] pte,
                       output logic [55:0] pa, output logic [5:0] ps, output int nr);
    logic [55:0] base, a, m;
    logic [63:0] d;
    int w, rem;
    bit fin;
    c = 0; ra = 0; pte = 0; pa = 0; ps = 0; nr = 0;
    if ((64'(pid) << 4) >= (64'd1 << (int'(sz) + 12))) begin c = 1; return; end
    a = (ptb & ~56'hF) + (56'(pid) << 4);
    d = rd(a); nr++;
    base = {d[55:8], 8'h0}; w = int'(d[4:0]); rem = int'(d[61:56]); fin = 0;
    for (int l = 0; l < 5 && !fin; l++) begin
      if (w < 5 || w > rem) begin c = 2; fin = 1; end
      else begin
        a = eaddr_of(base, w, rem, ea);
        d = rd(a); nr++;
        rem = rem - w;
        if (!d[63]) begin c = 1; fin = 1; end
        else if (d[62]) begin
          m = (rem >= 56) ? '1 : (56'd1 << rem) - 56'd1;
          ra = (d[55:0] & ~m) | (ea[55:0] & m);
          pte = d; pa = a; ps = 6'(rem); c = 0; fin = 1;
        end
        else if (l == 4) begin c = 2; fin = 1; end
        else begin base = {d[55:8], 8'h0}; w = int'(d[4:0]); end
      end
    end
  endtask

  task automatic do_walk(input string req, input logic [19:0] pid, input logic [4:0] sz,
                         input logic [63:0] ea, input bit intrude);
    logic [1:0] c; logic [55:0] ra, pa; logic [63:0] pte; logic [5:0] ps; int nr, n;
    logic [1:0] hc; logic [55:0] hr;
    model(pid, PTB, sz, ea, c, ra, pte, pa, ps, nr);
    reads = 0;
    @(negedge clk);
    walk_valid = 1'b1; walk_pid = pid; walk_ptab = PTB; walk_ptsz = sz; walk_ea = ea;
    @(negedge clk);
    walk_valid = 1'b0;
    if (intrude) begin
      repeat (3) @(negedge clk);
      chk("R10", "ready while busy", walk_ready, 1'b0);
      walk_valid = 1'b1; walk_pid = 20'd999; walk_ea = ~ea;
      @(negedge clk);
      walk_valid = 1'b0;
    end
    n = 0;
    while (!walk_done && n < 3000) begin @(negedge clk); n++; end
    chk(req, "done seen", walk_done, 1'b1);
    chk(req, "cause", walk_cause, c);
    if (c == 0) begin
      chk(req, "real", walk_real, ra);
      chk(req, "pte", walk_pte, pte);
      chk(req, "pte addr", walk_pte_addr, pa);
      chk(req, "psize", walk_psize, ps);
    end
    chk(req, "read count", reads, nr);
    hc = walk_cause; hr = walk_real;
    @(negedge clk);
    chk("R10", "done pulse", walk_done, 1'b0);
    chk("R10", "cause held", walk_cause, hc);
    chk("R10", "real held", walk_real, hr);
    chk("R10", "idle after walk", walk_ready, 1'b1);
  endtask

  task automatic t_reset();
    chk("R11", "ready", walk_ready, 1'b1);
    chk("R11", "done", walk_done, 1'b0);
    chk("R11", "mem req", mem_rd_valid, 1'b0);
  endtask

  task automatic t_bound();
    logic [63:0] ea = 64'hFFFF_00AB_CDEF_1234;
    mem.delete();
    do_walk("R1", 20'd256, 5'd0, ea, 0);
    chk("R1", "no read", reads, 0);
    chk("R1", "cause no-entry", walk_cause, 2'd1);
    mem[PTB + 56'hFF0] = pt_ent(56'h20000, 5, 40);
    mem[eaddr_of(56'h20000, 5, 40, ea)] = leaf_ent(56'h12345678_9ABCDE);
    do_walk("R2 R7", 20'd255, 5'd0, ea, 0);
    chk("R7", "large page size", walk_psize, 6'd35);
  endtask

  task automatic build3(input logic [63:0] ea);
    mem[PTB + 56'h30] = pt_ent(56'h30000, 6, 30);
    mem[eaddr_of(56'h30000, 6, 30, ea)] = dir_ent(56'h40000, 7);
    mem[eaddr_of(56'h40000, 7, 24, ea)] = dir_ent(56'h50000, 5);
    mem[eaddr_of(56'h50000, 5, 17, ea)] = leaf_ent(56'hABCDEF01234567);
  endtask

  task automatic t_three();
    logic [63:0] ea = 64'h0000_0000_2F5A_B6C7;
    mem.delete();
    stall = 1;
    build3(ea);
    do_walk("R5 R8", 20'd3, 5'd0, ea, 0);
    chk("R5", "psize", walk_psize, 6'd12);
    stall = 0;
    build3(64'h0000_0000_0123_4567);
    do_walk("R5 R8", 20'd3, 5'd0, 64'h0000_0000_0123_4567, 0);
  endtask

  task automatic t_invalid();
    logic [63:0] ea = 64'h0000_0000_1357_9BDF;
    mem.delete();
    mem[PTB + 56'h10] = pt_ent(56'h30000, 6, 30);
    mem[eaddr_of(56'h30000, 6, 30, ea)] = dir_ent(56'h40000, 7);
    do_walk("R6", 20'd1, 5'd0, ea, 0);
    chk("R6", "absent entry", walk_cause, 2'd1);
    mem[eaddr_of(56'h40000, 7, 24, ea)] = 64'h4000_0000_0000_0000 | 64'hABCDE000;
    do_walk("R6", 20'd1, 5'd0, ea, 0);
    chk("R6", "leaf bit without valid", walk_cause, 2'd1);
    chk("R6", "reads", reads, 3);
  endtask

  task automatic t_narrow();
    logic [63:0] ea = 64'h0000_0000_0ACE_BDF1;
    mem.delete();
    mem[PTB + 56'h20] = pt_ent(56'h30000, 4, 30);
    do_walk("R3", 20'd2, 5'd0, ea, 0);
    chk("R3", "root narrow reads", reads, 1);
    mem[PTB + 56'h20] = pt_ent(56'h30000, 6, 30);
    mem[eaddr_of(56'h30000, 6, 30, ea)] = dir_ent(56'h40000, 4);
    do_walk("R3", 20'd2, 5'd0, ea, 0);
    chk("R3", "level2 narrow cause", walk_cause, 2'd2);
    chk("R3", "level2 narrow reads", reads, 2);
  endtask

  task automatic t_wide();
    logic [63:0] ea = 64'h0000_0000_0000_03A5;
    mem.delete();
    mem[PTB + 56'h40] = pt_ent(56'h30000, 11, 10);
    do_walk("R4", 20'd4, 5'd0, ea, 0);
    chk("R4", "too wide cause", walk_cause, 2'd2);
    mem[PTB + 56'h40] = pt_ent(56'h30000, 10, 10);
    mem[eaddr_of(56'h30000, 10, 10, ea)] = leaf_ent(56'h00000777_654321);
    do_walk("R4 R7", 20'd4, 5'd0, ea, 0);
    chk("R7", "zero-size page real", walk_real, 56'h00000777_654321);
    chk("R7", "zero size", walk_psize, 6'd0);
  endtask

  task automatic t_depth();
    logic [63:0] ea = 64'h0000_00C3_A5F0_9E1B;
    logic [55:0] b [0:5];
    mem.delete();
    for (int i = 0; i < 6; i++) b[i] = 56'h60000 + 56'(i) * 56'h1000;
    mem[PTB + 56'h50] = pt_ent(b[0], 5, 40);
    for (int l = 0; l < 5; l++) mem[eaddr_of(b[l], 5, 40 - 5 * l, ea)] = dir_ent(b[l + 1], 5);
    do_walk("R9", 20'd5, 5'd0, ea, 0);
    chk("R9", "depth cause", walk_cause, 2'd2);
    chk("R9", "depth reads", reads, 6);
    mem[eaddr_of(b[4], 5, 20, ea)] = leaf_ent(56'h00ABCDEF_000000);
    do_walk("R9 R7", 20'd5, 5'd0, ea, 0);
    chk("R9", "fifth-level leaf psize", walk_psize, 6'd15);
  endtask

  task automatic t_busy();
    logic [63:0] ea = 64'h0000_0000_2F5A_B6C7;
    mem.delete();
    stall = 1;
    build3(ea);
    do_walk("R10", 20'd3, 5'd0, ea, 1);
    chk("R10", "intruder ignored reads", reads, 4);
    stall = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bound();
    t_three();
    t_invalid();
    t_narrow();
    t_wide();
    t_depth();
    t_busy();
    $display("  [TB] %0d tests run, %0d failed", ncheck, nfail);
    $finish;
  end
endmodule